// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block sits next to a program counter and runs up to three hardware loops with no cycle overhead. Each of the three controllers holds its own start address, end address and iteration count. On every fetch, the block compares the incoming PC with the end addresses of the armed loops. In the same cycle it either sends the next PC back to a loop start or lets the PC step by one.

The controllers have a fixed priority. Controller 0 is the innermost loop and has the highest priority; controller 2 is the outermost. Several nested loops may close on the same end address. In that case the highest-priority loop that still has iterations left takes the branch back. Inner loops that are exhausted at that shared address are reloaded, so they repeat on the next outer pass. When no loop at the address has iterations left, every exhausted loop there retires and the PC steps past the end.

Software programs a loop through a small write port. It selects a controller and a field, and writing the count arms the loop. A flush input drops every armed loop, for example on a pipeline redirect.

Top module: `loop_seq`

## Requirements
- R1: After reset all loops are inactive (`loop_active` = 0), `redirect` is 0, and `next_pc` equals `pc_in + 1`.
- R2: When `fetch_en` is low, or no armed loop has its end address equal to `pc_in`, `redirect` is 0 and `next_pc` is `pc_in + 1`, wrapping modulo 2^ADDR_W.
- R3: A write with `cfg_field` = 2 (count) and value N arms the selected loop for N branches back, so its body runs N+1 times per pass. N = 0 leaves the loop inactive. The write only affects fetches from the following cycle on.
- R4: In the cycle in which `pc_in` equals the end address of an armed loop with iterations left, `redirect` is 1 and `next_pc` is that loop's start address. That loop's remaining count drops by one.
- R5: When several armed loops with iterations left match `pc_in`, the loop with the lowest index takes the branch.
- R6: An exhausted loop fetched at its end address does not branch. Control falls through in the same cycle to the next-priority matching loop with iterations left, and otherwise to `pc_in + 1`. If no loop at that address branches, every exhausted matching loop becomes inactive.
- R7: When a loop takes the branch, every higher-priority exhausted loop matching the same address is reloaded with its programmed count and stays active. Loops sharing one end address therefore run the product of their (N+1) counts.
- R8: `flush` forces `redirect` to 0 in its cycle and leaves counts unchanged. It makes all loops inactive from the next cycle, and a count write in the same cycle is dropped.
- R9: Bit i of `loop_active` reports whether loop i is armed, with cfg_sel value i addressing loop i. A `cfg_sel` of NLOOP or more addresses no loop.
- R10: Writes with `cfg_field` = 0 (start address), 1 (end address) or 3 (reserved) change neither the active flags nor the remaining counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drops all armed loops and suppresses redirect |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Loop index to write |
| cfg_field | input | 2 | 0 start, 1 end, 2 count, 3 reserved |
| cfg_data | input | ADDR_W | Write data; count uses the low CNT_W bits |
| fetch_en | input | 1 | A fetch happens at `pc_in` this cycle |
| pc_in | input | ADDR_W | Address being fetched |
| next_pc | output | ADDR_W | Address for the next fetch |
| redirect | output | 1 | High when `next_pc` is a loop start |
| loop_active | output | NLOOP | Armed flag per loop |

## Verification
The bench lets the design drive its own PC and sweeps loop counts and start positions for three loops that share one end address. It then compares how often each address was fetched with the product formula. A design that fails to reload inner loops comes up short on inner-body fetches. A design that picks the wrong priority, or stalls when a loop exhausts, lands on the wrong start or fetches the end address too often. Loops with distinct end addresses are run to confirm that an exhausted inner loop stays retired (N0+1+N2 fetches). Directed cases check that a count write does not act on a fetch in the same cycle, that a flush beats a count write, that reserved writes leave the loops alone, and that fetches with `fetch_en` low are ignored.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

  typedef enum logic [1:0] {
    FLD_START = 2'd0,
    FLD_END   = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_RSVD  = 2'd3
  } cfg_field_e;

  // True when a write strobe targets a given field of a given slot.
  function automatic logic field_hit(input logic we, input logic sel_match,
                                     input logic [1:0] fld, input cfg_field_e want);
    return we && sel_match && (fld == want);
  endfunction

endpackage

// File: rtl/loop_seq_slot.sv
module loop_seq_slot #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic              wr_count,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              fetch_en,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              take,
  input  logic              reload,
  input  logic              retire,
  output logic [ADDR_W-1:0] start_q,
  output logic              end_hit,
  output logic              spent,
  output logic              armed
);

  logic [ADDR_W-1:0] start_r;
  logic [ADDR_W-1:0] end_r;
  logic [CNT_W-1:0]  prog_cnt_r;
  logic [CNT_W-1:0]  rem_r;
  logic              armed_r;
  logic [CNT_W-1:0]  wr_cnt;

  assign wr_cnt = wdata[CNT_W-1:0];

  // Address registers: independent of the arming state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_r <= '0;
      end_r   <= '0;
    end else begin
      if (wr_start) start_r <= wdata;
      if (wr_end)   end_r   <= wdata;
    end
  end

  // Count and arming state. Flush dominates, then a count write,
  // then the three mutually exclusive loop events.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_cnt_r <= '0;
      rem_r      <= '0;
      armed_r    <= 1'b0;
    end else if (flush) begin
      armed_r    <= 1'b0;
    end else if (wr_count) begin
      prog_cnt_r <= wr_cnt;
      rem_r      <= wr_cnt;
      armed_r    <= (wr_cnt != '0);
    end else if (take) begin
      rem_r      <= rem_r - CNT_W'(1);
    end else if (reload) begin
      rem_r      <= prog_cnt_r;
    end else if (retire) begin
      armed_r    <= 1'b0;
    end
  end

  assign start_q = start_r;
  assign end_hit = armed_r && fetch_en && (pc_in == end_r);
  assign spent   = (rem_r == '0);
  assign armed   = armed_r;

endmodule

// File: rtl/loop_seq_arb.sv
module loop_seq_arb #(
  parameter int NLOOP = 3
) (
  input  logic             flush,
  input  logic [NLOOP-1:0] hit_vec,
  input  logic [NLOOP-1:0] spent_vec,
  output logic [NLOOP-1:0] take_vec,
  output logic [NLOOP-1:0] reload_vec,
  output logic [NLOOP-1:0] retire_vec
);

  // Isolate the lowest set bit: index 0 has the highest priority.
  function automatic logic [NLOOP-1:0] lowest_one(input logic [NLOOP-1:0] v);
    return v & (~v + NLOOP'(1));
  endfunction

  // Mask of all bit positions below a one-hot bit (zero when none).
  function automatic logic [NLOOP-1:0] below_mask(input logic [NLOOP-1:0] oh);
    return (oh == '0) ? '0 : (oh - NLOOP'(1));
  endfunction

  logic [NLOOP-1:0] cand_vec;
  logic [NLOOP-1:0] done_vec;
  logic [NLOOP-1:0] winner;

  assign cand_vec = hit_vec & ~spent_vec;
  assign done_vec = hit_vec & spent_vec;
  assign winner   = lowest_one(cand_vec);

  always_comb begin
    take_vec   = '0;
    reload_vec = '0;
    retire_vec = '0;
    if (!flush) begin
      take_vec = winner;
      if (winner != '0) reload_vec = done_vec & below_mask(winner);
      else              retire_vec = done_vec;
    end
  end

endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int NLOOP  = 3,
  localparam int SEL_W = (NLOOP > 1) ? $clog2(NLOOP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              fetch_en,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] next_pc,
  output logic              redirect,
  output logic [NLOOP-1:0]  loop_active
);

  // Sequential step of the program counter.
  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] start_arr [NLOOP];
  logic [NLOOP-1:0]  hit_vec;
  logic [NLOOP-1:0]  spent_vec;
  logic [NLOOP-1:0]  take_vec;
  logic [NLOOP-1:0]  reload_vec;
  logic [NLOOP-1:0]  retire_vec;
  logic [ADDR_W-1:0] loop_target;

  for (genvar g = 0; g < NLOOP; g++) begin : g_slot
    logic sel_match;
    assign sel_match = (cfg_sel == SEL_W'(g));

    loop_seq_slot #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_start (field_hit(cfg_we, sel_match, cfg_field, FLD_START)),
      .wr_end   (field_hit(cfg_we, sel_match, cfg_field, FLD_END)),
      .wr_count (field_hit(cfg_we, sel_match, cfg_field, FLD_COUNT)),
      .wdata    (cfg_data),
      .fetch_en (fetch_en),
      .pc_in    (pc_in),
      .take     (take_vec[g]),
      .reload   (reload_vec[g]),
      .retire   (retire_vec[g]),
      .start_q  (start_arr[g]),
      .end_hit  (hit_vec[g]),
      .spent    (spent_vec[g]),
      .armed    (loop_active[g])
    );
  end

  loop_seq_arb #(
    .NLOOP (NLOOP)
  ) u_arb (
    .flush      (flush),
    .hit_vec    (hit_vec),
    .spent_vec  (spent_vec),
    .take_vec   (take_vec),
    .reload_vec (reload_vec),
    .retire_vec (retire_vec)
  );

  // AND-OR select of the winning start address (take_vec is one-hot or zero).
  always_comb begin
    loop_target = '0;
    for (int i = 0; i < NLOOP; i++) begin
      if (take_vec[i]) loop_target = loop_target | start_arr[i];
    end
  end

  assign redirect = (take_vec != '0);
  assign next_pc  = redirect ? loop_target : pc_step(pc_in);

endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk
  import loop_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int NLOOP  = 3,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              cfg_we,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [1:0]        cfg_field,
  input logic [ADDR_W-1:0] cfg_data,
  input logic              fetch_en,
  input logic [ADDR_W-1:0] pc_in,
  input logic [ADDR_W-1:0] next_pc,
  input logic              redirect,
  input logic [NLOOP-1:0]  loop_active,
  input logic [NLOOP-1:0]  hit_vec,
  input logic [NLOOP-1:0]  spent_vec,
  input logic [NLOOP-1:0]  take_vec,
  input logic [NLOOP-1:0]  reload_vec,
  input logic [NLOOP-1:0]  retire_vec
);

  // R2: no fetch means plain sequential flow
  p_idle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |-> (!redirect && next_pc == pc_in + ADDR_W'(1)));

  // R4: a matching loop with iterations left redirects in the same cycle
  p_zero_ovh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && ((hit_vec & ~spent_vec) != '0)) |-> redirect);

  // R4: a redirect needs an armed loop
  p_redir_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (loop_active != '0));

  // R5: at most one winner, and it is an eligible candidate
  p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec) && ((take_vec & ~(hit_vec & ~spent_vec)) == '0));

  // R6: a retired loop is inactive on the next cycle unless rewritten
  p_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vec != '0 && !cfg_we) |=> ((loop_active & $past(retire_vec)) == '0));

  // R7: a reloaded loop stays active
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_vec != '0 && !cfg_we) |=> ((loop_active & $past(reload_vec)) == $past(reload_vec)));

  // R8: flush suppresses redirect and clears the flags
  p_flush_redir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !redirect);
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (loop_active == '0));

  // R10: non-count writes with no loop event keep the flags
  p_no_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field != FLD_COUNT && !flush &&
     (reload_vec | retire_vec) == '0) |=> $stable(loop_active));

  for (genvar g = 0; g < NLOOP; g++) begin : g_arm
    // R3: a nonzero count write arms the selected loop
    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(g) && cfg_field == FLD_COUNT &&
       cfg_data[CNT_W-1:0] != '0 && !flush) |=> loop_active[g]);
  end

endmodule

bind loop_seq loop_seq_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .NLOOP  (NLOOP),
  .SEL_W  (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_field   (cfg_field),
  .cfg_data    (cfg_data),
  .fetch_en    (fetch_en),
  .pc_in       (pc_in),
  .next_pc     (next_pc),
  .redirect    (redirect),
  .loop_active (loop_active),
  .hit_vec     (hit_vec),
  .spent_vec   (spent_vec),
  .take_vec    (take_vec),
  .reload_vec  (reload_vec),
  .retire_vec  (retire_vec)
);

// File: tb/loop_seq_tb.sv
module loop_seq_tb;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int NLOOP  = 3;
  localparam int SEL_W  = 2;
  localparam int PC0    = 8;
  localparam int END_A  = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              cfg_we = 1'b0;
  logic [SEL_W-1:0]  cfg_sel = '0;
  logic [1:0]        cfg_field = '0;
  logic [ADDR_W-1:0] cfg_data = '0;
  logic              fetch_en = 1'b0;
  logic [ADDR_W-1:0] pc_in = '0;
  logic [ADDR_W-1:0] next_pc;
  logic              redirect;
  logic [NLOOP-1:0]  loop_active;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int hits [0:31];

  always #10 clk = ~clk;

  loop_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NLOOP(NLOOP)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .fetch_en(fetch_en), .pc_in(pc_in), .next_pc(next_pc),
    .redirect(redirect), .loop_active(loop_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 1'b0; flush = 1'b0; fetch_en = 1'b0;
  endtask

  task automatic wr(input int sel, input int fld, input int val);
    @(negedge clk);
    flush = 1'b0; fetch_en = 1'b0;
    cfg_we = 1'b1; cfg_sel = SEL_W'(sel); cfg_field = 2'(fld); cfg_data = ADDR_W'(val);
  endtask

  task automatic setup(input int sel, input int s, input int e, input int n);
    wr(sel, 0, s); wr(sel, 1, e); wr(sel, 2, n);
  endtask

  task automatic do_flush();
    @(negedge clk);
    cfg_we = 1'b0; fetch_en = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // Let the design steer its own PC from PC0 until it leaves past stop_a.
  task automatic run_prog(input int stop_a);
    int pc;
    int guard;
    for (int a = 0; a < 32; a++) hits[a] = 0;
    pc = PC0;
    guard = 0;
    while (pc <= stop_a && guard < 3000) begin
      @(negedge clk);
      cfg_we = 1'b0; flush = 1'b0; fetch_en = 1'b1; pc_in = ADDR_W'(pc);
      #1;
      hits[pc]++;
      pc = int'(next_pc);
      guard++;
    end
    @(negedge clk);
    fetch_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 / R9: reset state
    @(negedge clk);
    fetch_en = 1'b1; pc_in = 16'd5; #1;
    check(loop_active == 3'b000, "R1 active after reset", loop_active, 0);
    check(!redirect && next_pc == 16'd6, "R1 R2 step after reset", next_pc, 6);
    pc_in = 16'hFFFF; #1;
    check(next_pc == 16'h0000, "R2 wrap", next_pc, 0);

    // R3: count write in the same cycle as a matching fetch does not act
    wr(0, 0, 3); wr(0, 1, 5);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_field = 2'd2; cfg_data = 16'd2;
    fetch_en = 1'b1; pc_in = 16'd5; #1;
    check(!redirect && next_pc == 16'd6, "R3 write not yet visible", next_pc, 6);
    @(negedge clk);
    cfg_we = 1'b0; fetch_en = 1'b1; pc_in = 16'd5; #1;
    check(loop_active == 3'b001, "R9 loop0 flag", loop_active, 1);
    check(redirect && next_pc == 16'd3, "R4 loop back same cycle", next_pc, 3);

    // R2: fetch_en low ignores the end match
    @(negedge clk);
    fetch_en = 1'b0; pc_in = 16'd5; #1;
    check(!redirect && next_pc == 16'd6, "R2 fetch_en low", next_pc, 6);

    // R10: reserved and address writes leave flags alone
    wr(0, 3, 0);
    wr(1, 0, 40);
    idle();
    #1;
    check(loop_active == 3'b001, "R10 flags unchanged", loop_active, 1);
    @(negedge clk);
    fetch_en = 1'b1; pc_in = 16'd5; #1;
    check(redirect && next_pc == 16'd3, "R10 count kept", next_pc, 3);

    // R8: flush suppresses the redirect and clears flags
    @(negedge clk);
    fetch_en = 1'b1; flush = 1'b1; pc_in = 16'd5; #1;
    check(!redirect && next_pc == 16'd6, "R8 flush no redirect", next_pc, 6);
    idle(); #1;
    check(loop_active == 3'b000, "R8 flush clears", loop_active, 0);

    // R8: flush beats a count write
    @(negedge clk);
    flush = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd1; cfg_field = 2'd2; cfg_data = 16'd4;
    idle(); #1;
    check(loop_active == 3'b000, "R8 flush beats write", loop_active, 0);

    // R3: count zero leaves the loop off
    wr(2, 2, 0);
    idle(); #1;
    check(loop_active == 3'b000, "R3 zero count disabled", loop_active, 0);

    // R5: two loops on one end, loop 0 wins
    setup(0, 10, 12, 2);
    setup(1, 11, 12, 2);
    @(negedge clk);
    cfg_we = 1'b0; fetch_en = 1'b1; pc_in = 16'd12; #1;
    check(redirect && next_pc == 16'd10, "R5 priority", next_pc, 10);
    do_flush();

    // R4 R5 R6 R7: shared end sweep, expected counts from the product rule
    for (int s0 = END_A; s0 >= END_A - 3; s0 -= 3)
      for (int d1 = 0; d1 <= 2; d1 += 2)
        for (int d2 = 0; d2 <= 3; d2 += 3)
          for (int n0 = 0; n0 < 3; n0++)
            for (int n1 = 0; n1 < 3; n1++)
              for (int n2 = 0; n2 < 3; n2++) begin
                int s1;
                int s2;
                s1 = s0 - d1;
                s2 = s1 - d2;
                do_flush();
                setup(0, s0, END_A, n0);
                setup(1, s1, END_A, n1);
                setup(2, s2, END_A, n2);
                run_prog(END_A + 2);
                for (int a = PC0; a <= END_A + 2; a++) begin
                  int ex;
                  ex = 1;
                  if (a >= s0 && a <= END_A) ex = ex * (n0 + 1);
                  if (a >= s1 && a <= END_A) ex = ex * (n1 + 1);
                  if (a >= s2 && a <= END_A) ex = ex * (n2 + 1);
                  check(hits[a] == ex, "R7 shared-end fetch count", hits[a], ex);
                end
                check(loop_active == 3'b000, "R6 all retired", loop_active, 0);
              end

    // R6: distinct ends, exhausted inner loop stays retired
    for (int n0 = 0; n0 < 4; n0++)
      for (int n2 = 1; n2 < 4; n2++) begin
        do_flush();
        setup(0, 12, 14, n0);
        setup(2, 10, 18, n2);
        run_prog(20);
        for (int a = PC0; a <= 20; a++) begin
          int ex;
          ex = 1;
          if (a >= 12 && a <= 14)      ex = n0 + 1 + n2;
          else if (a >= 10 && a <= 18) ex = n2 + 1;
          check(hits[a] == ex, "R6 distinct-end fetch count", hits[a], ex);
        end
      end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule